// File: doc/BRIEF.md
# Partial Reconfiguration Session Controller

This block is a 64-bit register slave that a host uses to run one partial-reconfiguration session at a time. The host first puts the engine through a reset handshake. It then selects a target region, requests service, and pushes 32-bit configuration words through a data register. Finally it signals that the push is finished. A downstream consumer takes the pushed words. It pulses a done input when the new image has been applied, and it may raise error inputs at any time.

The host sees a control register, a status register, a sticky error register with write-1-to-clear semantics, a read-only header word and two read-only 64-bit compatibility constants. Reads are combinational from the byte offset on the address port. Writes take effect on the clock edge at which the write strobe is sampled. Bitstream parsing, CRC computation and fabric programming belong to the consumer, not to this block.

Top module: `pr_ctl_regs`

## Requirements
- R1: After reset, control, status and error read 0, push_valid_o is 0, and offsets 0x00, 0xA8 and 0xB0 return the HDR_VAL, ID_LO and ID_HI parameter values.
- R2: Writing control with bit 0 = 1 sets the reset request and enters engine state 1. Control bit 4 (reset acknowledge) reads 1 from the second edge after the write and stays 1 while bit 0 is held.
- R3: Writing control with bit 0 = 0 while a reset is requested clears bit 0 and bit 4 on that edge, returns the engine to state 0, and clears start and complete. A reset request also clears start and complete on a busy engine.
- R4: Control bits 9:7 store the 3-bit region identifier from every control write, read back there, and drive region_o.
- R5: Status bit 16 is 0 only in engine state 0. Status bits 22:20 carry the engine state: 0 idle, 1 reset, 2 busy, 3 draining. Writing control bit 12 = 1 in state 0 sets bit 12 and enters state 2. Writing bit 12 in any other state, or together with bit 0, has no effect on start.
- R6: Writing control bit 13 = 1 in state 2 sets bit 13 and enters state 3. In any other state bit 13 stays 0.
- R7: A data-register (0x18) write in state 2 raises push_valid_o for exactly the next cycle, with push_data_o equal to bits 31:0 of the written value.
- R8: A data-register write in any state other than 2 produces no push and sets error bit 3.
- R9: A cons_done_i pulse in state 2 or 3 returns the engine to state 0 and clears control bits 12 and 13. In other states it is ignored.
- R10: Error bits 4:0 (0 operation, 1 CRC, 2 incompatible image, 3 protocol, 4 overflow) are set by cons_err_i of the same index and stay set. A write to 0x20 clears each bit written as 1, and a set in the same cycle wins over the clear.
- R11: Status bits 27:24 read {reset acknowledge, reset request, complete, start} from bit 27 down to bit 24.
- R12: Writes to 0x00, 0xA8 and 0xB0 have no effect. The data register and all unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Byte offset for read and write |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for reg_addr_i |
| push_valid_o | output | 1 | Configuration word valid, one cycle per accepted word |
| push_data_o | output | PUSH_W | Configuration word toward the intake path |
| region_o | output | RGN_W | Selected target region |
| cons_done_i | input | 1 | Consumer reports the image applied |
| cons_err_i | input | ERR_W | Consumer error pulses, one per error flag |

## Verification
The bench pushes data words before start, after complete and during reset. A design that gated pushes on the start bit alone would forward words while draining and miss the protocol flag. It releases reset with start and region bits in the same write, and issues a done pulse on the same cycle as a complete request. A design with the wrong priority there would leave the engine stuck in draining or busy. It also clears the error register in the same cycle as a new consumer error, so a clear that wins over the set drops a fresh flag. It checks that the acknowledge appears only one edge after the engine enters reset and drops on the release edge.

// File: rtl/pr_ctl_pkg.sv
package pr_ctl_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE  = 3'd0,
    ENG_RESET = 3'd1,
    ENG_BUSY  = 3'd2,
    ENG_DRAIN = 3'd3
  } eng_state_e;

  localparam int ERR_W      = 5;
  localparam int ERR_PROTO  = 3;

  localparam logic [7:0] OFF_HDR  = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_DATA = 8'h18;
  localparam logic [7:0] OFF_ERR  = 8'h20;
  localparam logic [7:0] OFF_IDL  = 8'hA8;
  localparam logic [7:0] OFF_IDH  = 8'hB0;

  // control field positions
  localparam int CTL_RST     = 0;
  localparam int CTL_ACK     = 4;
  localparam int CTL_RGN_LSB = 7;
  localparam int CTL_START   = 12;
  localparam int CTL_COMP    = 13;

  // status field positions
  localparam int STS_BUSY     = 16;
  localparam int STS_ENG_LSB  = 20;
  localparam int STS_ENG_W    = 3;
  localparam int STS_HOST_LSB = 24;
  localparam int STS_HOST_W   = 4;

endpackage

// File: rtl/pr_ctl_seq.sv
module pr_ctl_seq
  import pr_ctl_pkg::*;
#(
  parameter int RGN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_wr_i,
  input  logic             rst_bit_i,
  input  logic             start_bit_i,
  input  logic             comp_bit_i,
  input  logic [RGN_W-1:0] region_i,
  input  logic             done_i,
  output eng_state_e       state_o,
  output logic             rst_req_o,
  output logic             ack_o,
  output logic             start_o,
  output logic             comp_o,
  output logic [RGN_W-1:0] region_o
);

  eng_state_e       state_q;
  logic             rst_req_q, ack_q, start_q, comp_q;
  logic [RGN_W-1:0] region_q;
  logic             active;

  assign active = (state_q == ENG_BUSY) || (state_q == ENG_DRAIN);

  // later assignments take priority: reset > done > start/complete
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ENG_IDLE;
      rst_req_q <= 1'b0;
      ack_q     <= 1'b0;
      start_q   <= 1'b0;
      comp_q    <= 1'b0;
      region_q  <= '0;
    end else begin
      if (state_q == ENG_RESET && rst_req_q) ack_q <= 1'b1;

      if (ctrl_wr_i && !rst_bit_i && !rst_req_q) begin
        if (start_bit_i && state_q == ENG_IDLE) begin
          start_q <= 1'b1;
          state_q <= ENG_BUSY;
        end
        if (comp_bit_i && state_q == ENG_BUSY) begin
          comp_q  <= 1'b1;
          state_q <= ENG_DRAIN;
        end
      end

      if (done_i && active) begin
        state_q <= ENG_IDLE;
        start_q <= 1'b0;
        comp_q  <= 1'b0;
      end

      if (ctrl_wr_i) begin
        region_q <= region_i;
        if (rst_bit_i) begin
          rst_req_q <= 1'b1;
          state_q   <= ENG_RESET;
          start_q   <= 1'b0;
          comp_q    <= 1'b0;
        end else if (rst_req_q) begin
          rst_req_q <= 1'b0;
          ack_q     <= 1'b0;
          state_q   <= ENG_IDLE;
        end
      end
    end
  end

  assign state_o   = state_q;
  assign rst_req_o = rst_req_q;
  assign ack_o     = ack_q;
  assign start_o   = start_q;
  assign comp_o    = comp_q;
  assign region_o  = region_q;

endmodule

// File: rtl/pr_ctl_push.sv
module pr_ctl_push
  import pr_ctl_pkg::*;
#(
  parameter int PUSH_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_wr_i,
  input  logic [PUSH_W-1:0] word_i,
  input  eng_state_e        state_i,
  output logic              valid_o,
  output logic [PUSH_W-1:0] data_o,
  output logic              proto_err_o
);

  logic              accept;
  logic              valid_q;
  logic [PUSH_W-1:0] data_q;

  assign accept      = data_wr_i && (state_i == ENG_BUSY);
  assign proto_err_o = data_wr_i && !accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= accept;
      if (accept) data_q <= word_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

endmodule

// File: rtl/pr_ctl_err.sv
module pr_ctl_err
  import pr_ctl_pkg::*;
#(
  parameter int EW = ERR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_wr_i,
  input  logic [EW-1:0] clr_mask_i,
  input  logic [EW-1:0] ext_err_i,
  input  logic          proto_i,
  output logic [EW-1:0] err_o
);

  logic [EW-1:0] err_q;
  logic [EW-1:0] set_v;

  for (genvar i = 0; i < EW; i++) begin : g_flag
    if (i == ERR_PROTO) begin : g_proto
      assign set_v[i] = ext_err_i[i] | proto_i;
    end else begin : g_ext
      assign set_v[i] = ext_err_i[i];
    end

    // set wins over a simultaneous clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) err_q[i] <= 1'b0;
      else         err_q[i] <= (err_q[i] & ~(clr_wr_i & clr_mask_i[i])) | set_v[i];
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/pr_ctl_regs.sv
module pr_ctl_regs
  import pr_ctl_pkg::*;
#(
  parameter int          DW      = 64,
  parameter int          AW      = 8,
  parameter int          RGN_W   = 3,
  parameter int          PUSH_W  = 32,
  parameter logic [63:0] HDR_VAL = 64'h3000_0000_1000_0005,
  parameter logic [63:0] ID_LO   = 64'h0123_4567_89AB_CDEF,
  parameter logic [63:0] ID_HI   = 64'hFEDC_BA98_7654_3210
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              push_valid_o,
  output logic [PUSH_W-1:0] push_data_o,
  output logic [RGN_W-1:0]  region_o,
  input  logic              cons_done_i,
  input  logic [ERR_W-1:0]  cons_err_i
);

  localparam logic [AW-1:0] A_HDR  = AW'(OFF_HDR);
  localparam logic [AW-1:0] A_CTRL = AW'(OFF_CTRL);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_DATA = AW'(OFF_DATA);
  localparam logic [AW-1:0] A_ERR  = AW'(OFF_ERR);
  localparam logic [AW-1:0] A_IDL  = AW'(OFF_IDL);
  localparam logic [AW-1:0] A_IDH  = AW'(OFF_IDH);

  logic             ctrl_wr, data_wr, err_wr;
  eng_state_e       eng_state;
  logic             rst_req_q, ack_q, start_q, comp_q;
  logic             proto_err;
  logic [ERR_W-1:0] err_q;
  logic [DW-1:0]    ctrl_rd, stat_rd;
  logic             unused_wdata;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == A_CTRL);
  assign data_wr = reg_wr_i && (reg_addr_i == A_DATA);
  assign err_wr  = reg_wr_i && (reg_addr_i == A_ERR);
  assign unused_wdata = ^reg_wdata_i;

  pr_ctl_seq #(.RGN_W(RGN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .rst_bit_i   (reg_wdata_i[CTL_RST]),
    .start_bit_i (reg_wdata_i[CTL_START]),
    .comp_bit_i  (reg_wdata_i[CTL_COMP]),
    .region_i    (reg_wdata_i[CTL_RGN_LSB +: RGN_W]),
    .done_i      (cons_done_i),
    .state_o     (eng_state),
    .rst_req_o   (rst_req_q),
    .ack_o       (ack_q),
    .start_o     (start_q),
    .comp_o      (comp_q),
    .region_o    (region_o)
  );

  pr_ctl_push #(.PUSH_W(PUSH_W)) u_push (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .data_wr_i   (data_wr),
    .word_i      (reg_wdata_i[PUSH_W-1:0]),
    .state_i     (eng_state),
    .valid_o     (push_valid_o),
    .data_o      (push_data_o),
    .proto_err_o (proto_err)
  );

  pr_ctl_err #(.EW(ERR_W)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_wr_i   (err_wr),
    .clr_mask_i (reg_wdata_i[ERR_W-1:0]),
    .ext_err_i  (cons_err_i),
    .proto_i    (proto_err),
    .err_o      (err_q)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTL_RST]                  = rst_req_q;
    ctrl_rd[CTL_ACK]                  = ack_q;
    ctrl_rd[CTL_RGN_LSB +: RGN_W]     = region_o;
    ctrl_rd[CTL_START]                = start_q;
    ctrl_rd[CTL_COMP]                 = comp_q;
  end

  always_comb begin
    stat_rd = '0;
    stat_rd[STS_BUSY]                    = (eng_state != ENG_IDLE);
    stat_rd[STS_ENG_LSB +: STS_ENG_W]    = eng_state;
    stat_rd[STS_HOST_LSB +: STS_HOST_W]  = {ack_q, rst_req_q, comp_q, start_q};
  end

  always_comb begin
    case (reg_addr_i)
      A_HDR:   reg_rdata_o = DW'(HDR_VAL);
      A_CTRL:  reg_rdata_o = ctrl_rd;
      A_STAT:  reg_rdata_o = stat_rd;
      A_ERR:   reg_rdata_o = DW'(err_q);
      A_IDL:   reg_rdata_o = DW'(ID_LO);
      A_IDH:   reg_rdata_o = DW'(ID_HI);
      default: reg_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/pr_ctl_chk.sv
module pr_ctl_chk
  import pr_ctl_pkg::*;
#(
  parameter int AW = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic [AW-1:0]    reg_addr_i,
  input logic             push_valid_o,
  input logic             cons_done_i,
  input logic [2:0]       state_i,
  input logic             rst_req_i,
  input logic             ack_i,
  input logic             start_i,
  input logic             comp_i,
  input logic [ERR_W-1:0] err_i
);

  // R7
  push_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_o |-> $past(reg_wr_i && reg_addr_i == AW'(OFF_DATA)));

  // R2
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> rst_req_i);

  // R3
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_i) |-> (state_i == 3'd0 && !ack_i && !start_i && !comp_i));

  // R9
  done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cons_done_i && (state_i == 3'd2 || state_i == 3'd3)
     && !(reg_wr_i && reg_addr_i == AW'(OFF_CTRL))) |=> (!start_i && !comp_i));

  // R10
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == AW'(OFF_ERR)) |=> ((err_i & $past(err_i)) == $past(err_i)));

  // R5
  idle_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == 3'd0) |-> (!start_i && !comp_i));

  // R6
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_i |-> (start_i && state_i == 3'd3));

endmodule

bind pr_ctl_regs pr_ctl_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .push_valid_o (push_valid_o),
  .cons_done_i  (cons_done_i),
  .state_i      (eng_state),
  .rst_req_i    (rst_req_q),
  .ack_i        (ack_q),
  .start_i      (start_q),
  .comp_i       (comp_q),
  .err_i        (err_q)
);

// File: tb/pr_ctl_regs_test.sv
module pr_ctl_regs_test;

  localparam logic [63:0] HDR = 64'h3000_0000_1000_0005;
  localparam logic [63:0] IDL = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] IDH = 64'hFEDC_BA98_7654_3210;
  localparam logic [7:0] O_HDR = 8'h00, O_CTL = 8'h08, O_STS = 8'h10,
                         O_DAT = 8'h18, O_ERR = 8'h20, O_IDL = 8'hA8, O_IDH = 8'hB0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        pv;
  logic [31:0] pd;
  logic [2:0]  rgn;
  logic        done = 1'b0;
  logic [4:0]  cerr = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pr_ctl_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .push_valid_o(pv),
    .push_data_o(pd), .region_o(rgn), .cons_done_i(done), .cons_err_i(cerr)
  );

  // reference model state
  bit       m_rst, m_ack, m_start, m_comp, m_pv;
  int       m_st;
  bit [2:0] m_rgn;
  bit [4:0] m_err;
  bit [31:0] m_pd;
  int       push_q[$];

  function automatic logic [63:0] m_read(input logic [7:0] a);
    logic [63:0] v = '0;
    case (a)
      O_HDR: v = HDR;
      O_CTL: begin v[0] = m_rst; v[4] = m_ack; v[9:7] = m_rgn; v[12] = m_start; v[13] = m_comp; end
      O_STS: begin v[16] = (m_st != 0); v[22:20] = 3'(m_st); v[27:24] = {m_ack, m_rst, m_comp, m_start}; end
      O_ERR: v[4:0] = m_err;
      O_IDL: v = IDL;
      O_IDH: v = IDH;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic m_step(input logic w, input logic [7:0] a, input logic [63:0] d,
                        input logic dn, input logic [4:0] ce);
    bit n_rst = m_rst, n_ack = m_ack, n_start = m_start, n_comp = m_comp;
    int n_st = m_st;
    bit [2:0] n_rgn = m_rgn;
    bit proto = 0;
    m_pv = 0;
    if (m_st == 1 && m_rst) n_ack = 1;
    if (w && a == O_DAT) begin
      if (m_st == 2) begin m_pv = 1; m_pd = d[31:0]; push_q.push_back(int'(d[31:0])); end
      else proto = 1;
    end
    if (w && a == O_CTL && !d[0] && !m_rst) begin
      if (d[12] && m_st == 0) begin n_start = 1; n_st = 2; end
      if (d[13] && m_st == 2) begin n_comp = 1; n_st = 3; end
    end
    if (dn && (m_st == 2 || m_st == 3)) begin n_st = 0; n_start = 0; n_comp = 0; end
    if (w && a == O_CTL) begin
      n_rgn = d[9:7];
      if (d[0]) begin n_rst = 1; n_st = 1; n_start = 0; n_comp = 0; end
      else if (m_rst) begin n_rst = 0; n_ack = 0; n_st = 0; end
    end
    m_err = (m_err & ~((w && a == O_ERR) ? d[4:0] : 5'd0)) | ce | (proto ? 5'b01000 : 5'd0);
    m_rst = n_rst; m_ack = n_ack; m_start = n_start; m_comp = n_comp; m_st = n_st; m_rgn = n_rgn;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string addr_tag(input logic [7:0] a);
    case (a)
      O_CTL: return "R2 control readback";
      O_STS: return "R5 status readback";
      O_ERR: return "R10 error readback";
      default: return "R12 constant/unmapped readback";
    endcase
  endfunction

  // one clock: drive, model on the edge, compare at the falling edge
  task automatic cyc(input logic w, input logic [7:0] a, input logic [63:0] d,
                     input logic dn = 1'b0, input logic [4:0] ce = 5'd0);
    wr = w; addr = a; wdata = d; done = dn; cerr = ce;
    @(posedge clk);
    m_step(w, a, d, dn, ce);
    @(negedge clk);
    wr = 1'b0; done = 1'b0; cerr = '0;
    chk(addr_tag(a), rdata, m_read(a));
    chk("R7 push valid", 64'(pv), 64'(m_pv));
    if (m_pv) chk("R7 push data", 64'(pd), 64'(m_pd));
    chk("R4 region_o", 64'(rgn), 64'(m_rgn));
  endtask

  task automatic rdexp(input logic [7:0] a, input logic [63:0] exp, input string tag);
    cyc(1'b0, a, 64'd0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    m_st = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 push_valid after reset", 64'(pv), 64'd0);
    rdexp(O_HDR, HDR, "R1 header");
    rdexp(O_IDL, IDL, "R1 id low");
    rdexp(O_IDH, IDH, "R1 id high");
    rdexp(O_CTL, 64'd0, "R1 control");
    rdexp(O_STS, 64'd0, "R1 status");
    rdexp(O_ERR, 64'd0, "R1 error");

    // R12 read-only constants, unmapped reads
    cyc(1'b1, O_IDL, 64'h5555_AAAA_5555_AAAA);
    cyc(1'b1, O_HDR, 64'hFFFF_FFFF_FFFF_FFFF);
    rdexp(O_IDL, IDL, "R12 id low after write");
    rdexp(O_HDR, HDR, "R12 header after write");
    rdexp(8'h28, 64'd0, "R12 unmapped");
    rdexp(O_DAT, 64'd0, "R12 data reads zero");

    // R8 push while idle
    cyc(1'b1, O_DAT, 64'h0000_0000_DEAD_BEEF);
    chk("R8 no push when idle", 64'(pv), 64'd0);
    rdexp(O_ERR, 64'h8, "R8 protocol flag");
    // R10 write-1-to-clear
    cyc(1'b1, O_ERR, 64'h8);
    rdexp(O_ERR, 64'h0, "R10 w1c clear");

    // R2 reset handshake
    cyc(1'b1, O_CTL, 64'h1);
    chk("R2 ack not yet", rdata, m_read(O_CTL));
    rdexp(O_CTL, 64'h11, "R2 ack raised");
    rdexp(O_STS, 64'h0C11_0000, "R11 host state during reset");
    cyc(1'b1, O_CTL, 64'h1001);          // start while reset held
    rdexp(O_CTL, 64'h11, "R5 start ignored in reset");
    // R3 release with region 5 and start in the same write
    cyc(1'b1, O_CTL, 64'h1280);
    rdexp(O_CTL, 64'h280, "R3 release clears ack");
    rdexp(O_STS, 64'h0, "R3 idle after release");
    chk("R4 region_o", 64'(rgn), 64'd5);

    // R5 start
    cyc(1'b1, O_CTL, 64'h1280);
    rdexp(O_STS, 64'h0121_0000, "R5 busy after start");
    // R7 back-to-back pushes
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, O_DAT, 64'hABCD_0000_1000_0000 + 64'(i * 7));
      chk("R7 push valid per word", 64'(pv), 64'd1);
      chk("R7 push word", 64'(pd), 64'(32'h1000_0000 + 32'(i * 7)));
    end
    rdexp(O_CTL, 64'h1280, "R7 idle read");
    chk("R7 push drops", 64'(pv), 64'd0);
    // R6 complete
    cyc(1'b1, O_CTL, 64'h3280);
    rdexp(O_STS, 64'h0331_0000, "R6 draining");
    cyc(1'b1, O_DAT, 64'h1234);
    chk("R8 no push after complete", 64'(pv), 64'd0);
    rdexp(O_ERR, 64'h8, "R8 protocol after complete");
    // R9 done
    cyc(1'b0, O_CTL, 64'd0, 1'b1);
    rdexp(O_CTL, 64'h280, "R9 start and complete cleared");
    rdexp(O_STS, 64'h0, "R9 idle");
    cyc(1'b0, O_STS, 64'd0, 1'b1);
    rdexp(O_STS, 64'h0, "R9 done ignored when idle");

    // R10 sticky consumer errors, set wins over clear
    cyc(1'b0, O_ERR, 64'd0, 1'b0, 5'b00001);
    cyc(1'b0, O_ERR, 64'd0, 1'b0, 5'b10110);
    rdexp(O_ERR, 64'h1F, "R10 all flags sticky");
    cyc(1'b1, O_ERR, 64'h03, 1'b0, 5'b00010);
    rdexp(O_ERR, 64'h1E, "R10 set wins same cycle");
    cyc(1'b1, O_ERR, 64'hFF);
    rdexp(O_ERR, 64'h0, "R10 full clear");

    // done on busy, complete and done together, reset on busy
    cyc(1'b1, O_CTL, 64'h1000);
    cyc(1'b1, O_CTL, 64'h3000, 1'b1);
    rdexp(O_STS, 64'h0, "R9 done beats complete");
    cyc(1'b1, O_CTL, 64'h2000);
    rdexp(O_CTL, 64'h0, "R6 complete ignored when idle");
    cyc(1'b1, O_CTL, 64'h1100);
    cyc(1'b1, O_CTL, 64'h1101);
    rdexp(O_CTL, 64'h111, "R3 reset clears start");
    cyc(1'b1, O_DAT, 64'h77);
    chk("R8 no push in reset", 64'(pv), 64'd0);
    cyc(1'b1, O_CTL, 64'h0);
    rdexp(O_STS, 64'h0, "R3 idle after second release");
    rdexp(O_ERR, 64'h8, "R8 flag from reset push");
    chk("R7 words pushed", 64'(push_q.size()), 64'd4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule